// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper for One H-Bridge

This block regulates the winding current of one motor phase by switching the four transistors of an H-bridge. It turns the bridge on in the direction given by `polarity`. An external current comparator raises `trip` when the sensed current reaches its threshold. Once a trip is taken, the bridge is held off for a fixed number of clock cycles before it turns on again. The comparator is not looked at for a programmable blanking window after each turn-on. This hides the switching spike that follows every turn-on.

During the off-time the bridge recirculates current in one of two ways. Slow decay turns on both low-side switches. Mixed decay first reverses the bridge (fast decay) for a programmed part of the off-time, then shorts the winding through both low sides for the rest. Both decay styles use synchronous rectification: transistors conduct the current instead of the body diodes. The decay style is chosen at the moment of the trip from `trend_dec`, the translator's flag that the target current is falling. Every change of switch pattern passes through an all-off dead interval, so the two switches of one leg never conduct together. All four durations (off-time, blanking, fast part, dead time) are runtime inputs counted in clock cycles.

Top module: `foc_chopper`

## Requirements
- R1: While `rst_n` is low, and in every cycle where `enable` is low, all four gate outputs are 0.
- R2: When the bridge is turned on, the gates first stay all-off for `dead_cycles` cycles. This applies after `enable` rises and after each off-time ends. The drive pattern follows the dead interval.
- R3: The drive pattern is held for `blank_cycles` cycles after each turn-on, and `trip` is ignored during this window.
- R4: When `trip` is high in a cycle after the blanking window, the drive pattern ends at the next clock edge. The gates then stay in non-drive patterns for exactly `off_cycles` cycles, counted from the first off cycle. Without a trip, the drive pattern is held.
- R5: The decay style is latched at the trip edge. If `trend_dec` is 1 at that edge, mixed decay is used; if it is 0, slow decay is used. Later changes of `trend_dec` have no effect on the current off-time.
- R6: The mixed off-time runs in this order: `dead_cycles` all-off, then `fast_cycles` of fast decay, then `dead_cycles` all-off, then slow decay for the rest of the off-time. This requires `off_cycles` >= 2*`dead_cycles` + `fast_cycles` + 1.
- R7: The slow off-time is `dead_cycles` all-off followed by slow decay for the rest of the off-time. This requires `off_cycles` >= `dead_cycles` + 1.
- R8: The gate code is {a_hi, a_lo, b_hi, b_lo}. Drive is 1001 for polarity 0 and 0110 for polarity 1. Fast decay is the opposite code of drive. Slow decay is 0101. `polarity` is sampled only when a turn-on dead interval starts, so a change at any other time has no effect until the next turn-on.
- R9: The high and low switch of the same leg are never both 1. A change from one non-zero pattern to a different non-zero pattern always passes through at least one all-off cycle.
- R10: When `enable` falls, all gates go to 0 in the same cycle and the controller returns to idle. The next rise of `enable` starts again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the chopper; low forces all gates off |
| trip | input | 1 | Current comparator: sensed current reached the trip level |
| trend_dec | input | 1 | Target current is falling (selects mixed decay) |
| polarity | input | 1 | Current direction: 0 drives A high/B low, 1 drives B high/A low |
| off_cycles | input | CNT_W | Fixed off-time length in cycles |
| blank_cycles | input | CNT_W | Comparator blanking after turn-on, in cycles (>= 1) |
| fast_cycles | input | CNT_W | Fast-decay part of a mixed off-time, in cycles (>= 1) |
| dead_cycles | input | CNT_W | All-off crossover interval, in cycles (>= 1) |
| gate_a_hi | output | 1 | Leg A high-side switch |
| gate_a_lo | output | 1 | Leg A low-side switch |
| gate_b_hi | output | 1 | Leg B high-side switch |
| gate_b_lo | output | 1 | Leg B low-side switch |

## Verification
The bench goes after the exact cycle boundaries. It checks the smallest legal off-time, where the slow part lasts a single cycle. A timer that is off by one would cut the drive short, stretch the off-time, or skip the final slow cycle. The comparator is held high through the whole blanking window. A design that does not blank would chop right after turn-on. `polarity` and `trend_dec` are changed in the middle of the off-time. A design that samples them continuously would flip the decay pattern, or switch to the new direction before the dead interval. Dropping `enable` partway through an off-time exposes gates that linger, and a restart that skips its dead interval.

// File: rtl/foc_pkg.sv
package foc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ON_BLANK = 3'd1,
      ST_ON       = 3'd2,
      ST_DEAD     = 3'd3,
      ST_FAST     = 3'd4,
      ST_SLOW     = 3'd5
   } foc_state_e;

   typedef struct packed {
      logic a_hi;
      logic a_lo;
      logic b_hi;
      logic b_lo;
   } foc_gates_t;

   localparam int DECAY_AUTO  = 0;
   localparam int DECAY_SLOW  = 1;
   localparam int DECAY_MIXED = 2;

endpackage

// File: rtl/foc_timer.sv
module foc_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // once drained the count stays at zero until reloaded (off-time length, R4)
   assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

   // a count never moves up unless reloaded
   assert_no_climb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/foc_decay_sel.sv
module foc_decay_sel #(
   parameter int MODE = foc_pkg::DECAY_AUTO
) (
   input  logic trend_dec,
   output logic use_mixed
);

   generate
      if (MODE == foc_pkg::DECAY_AUTO) begin : g_auto
         assign use_mixed = trend_dec;
      end else if (MODE == foc_pkg::DECAY_MIXED) begin : g_mixed
         logic unused_trend;
         assign unused_trend = trend_dec;
         assign use_mixed    = 1'b1;
      end else begin : g_slow
         logic unused_trend;
         assign unused_trend = trend_dec;
         assign use_mixed    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/foc_gate_map.sv
module foc_gate_map
   import foc_pkg::*;
(
   input  foc_state_e st,
   input  logic       pol,
   input  logic       enable,
   output foc_gates_t gates
);

   foc_gates_t drive_pat;
   foc_gates_t fast_pat;
   foc_gates_t slow_pat;

   always_comb begin
      drive_pat = pol ? '{a_hi: 1'b0, a_lo: 1'b1, b_hi: 1'b1, b_lo: 1'b0}
                      : '{a_hi: 1'b1, a_lo: 1'b0, b_hi: 1'b0, b_lo: 1'b1};
      fast_pat  = pol ? '{a_hi: 1'b1, a_lo: 1'b0, b_hi: 1'b0, b_lo: 1'b1}
                      : '{a_hi: 1'b0, a_lo: 1'b1, b_hi: 1'b1, b_lo: 1'b0};
      slow_pat  = '{a_hi: 1'b0, a_lo: 1'b1, b_hi: 1'b0, b_lo: 1'b1};
   end

   always_comb begin
      gates = '0;
      case (st)
         ST_ON_BLANK, ST_ON: gates = drive_pat;
         ST_FAST:            gates = fast_pat;
         ST_SLOW:            gates = slow_pat;
         default:            gates = '0;
      endcase
      if (!enable) begin
         gates = '0;
      end
   end

endmodule

// File: rtl/foc_chopper.sv
module foc_chopper
   import foc_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int DECAY_MODE = DECAY_AUTO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             trip,
   input  logic             trend_dec,
   input  logic             polarity,
   input  logic [CNT_W-1:0] off_cycles,
   input  logic [CNT_W-1:0] blank_cycles,
   input  logic [CNT_W-1:0] fast_cycles,
   input  logic [CNT_W-1:0] dead_cycles,
   output logic             gate_a_hi,
   output logic             gate_a_lo,
   output logic             gate_b_hi,
   output logic             gate_b_lo
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("foc_chopper: CNT_W must lie in 2..32");
      end
      if (DECAY_MODE < DECAY_AUTO || DECAY_MODE > DECAY_MIXED) begin : g_bad_mode
         $error("foc_chopper: DECAY_MODE must be auto, slow or mixed");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] span_to_load(input logic [CNT_W-1:0] span);
      return (span == CNT_ZERO) ? CNT_ZERO : span - 1'b1;
   endfunction

   foc_state_e       st_q, st_n;
   foc_state_e       tgt_q, tgt_n;
   logic             pol_q, pol_n;
   logic             ph_load, off_load;
   logic [CNT_W-1:0] ph_val;
   logic             ph_done, off_done;
   logic             use_mixed;
   foc_gates_t       gates;
   logic [3:0]       gate_vec;

   foc_timer #(.CNT_W(CNT_W)) u_phase_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .expired  (ph_done)
   );

   foc_timer #(.CNT_W(CNT_W)) u_off_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (off_load),
      .load_val (span_to_load(off_cycles)),
      .expired  (off_done)
   );

   foc_decay_sel #(.MODE(DECAY_MODE)) u_decay (
      .trend_dec (trend_dec),
      .use_mixed (use_mixed)
   );

   always_comb begin
      st_n     = st_q;
      tgt_n    = tgt_q;
      pol_n    = pol_q;
      ph_load  = 1'b0;
      ph_val   = CNT_ZERO;
      off_load = 1'b0;
      case (st_q)
         ST_IDLE: begin
            st_n    = ST_DEAD;
            tgt_n   = ST_ON_BLANK;
            pol_n   = polarity;
            ph_load = 1'b1;
            ph_val  = span_to_load(dead_cycles);
         end
         ST_DEAD: begin
            if (ph_done) begin
               st_n = tgt_q;
               if (tgt_q == ST_ON_BLANK) begin
                  ph_load = 1'b1;
                  ph_val  = span_to_load(blank_cycles);
               end else if (tgt_q == ST_FAST) begin
                  ph_load = 1'b1;
                  ph_val  = span_to_load(fast_cycles);
               end
            end
         end
         ST_ON_BLANK: begin
            if (ph_done) begin
               st_n = ST_ON;
            end
         end
         ST_ON: begin
            if (trip) begin
               st_n     = ST_DEAD;
               tgt_n    = use_mixed ? ST_FAST : ST_SLOW;
               ph_load  = 1'b1;
               ph_val   = span_to_load(dead_cycles);
               off_load = 1'b1;
            end
         end
         ST_FAST: begin
            if (ph_done) begin
               st_n    = ST_DEAD;
               tgt_n   = ST_SLOW;
               ph_load = 1'b1;
               ph_val  = span_to_load(dead_cycles);
            end
         end
         ST_SLOW: begin
            if (off_done) begin
               st_n    = ST_DEAD;
               tgt_n   = ST_ON_BLANK;
               pol_n   = polarity;
               ph_load = 1'b1;
               ph_val  = span_to_load(dead_cycles);
            end
         end
         default: begin
            st_n = ST_IDLE;
         end
      endcase
      if (!enable) begin
         st_n     = ST_IDLE;
         ph_load  = 1'b0;
         off_load = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         tgt_q <= ST_ON_BLANK;
         pol_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         tgt_q <= tgt_n;
         pol_q <= pol_n;
      end
   end

   foc_gate_map u_map (
      .st     (st_q),
      .pol    (pol_q),
      .enable (enable),
      .gates  (gates)
   );

   assign gate_a_hi = gates.a_hi;
   assign gate_a_lo = gates.a_lo;
   assign gate_b_hi = gates.b_hi;
   assign gate_b_lo = gates.b_lo;
   assign gate_vec  = {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};

   assert_leg_a_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_a_hi && gate_a_lo));

   assert_leg_b_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_b_hi && gate_b_lo));

   assert_dead_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_vec != 4'b0000 && $past(gate_vec) != 4'b0000) |-> (gate_vec == $past(gate_vec)));

   assert_blank_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ON_BLANK && enable) |=> (st_q == ST_ON_BLANK || st_q == ST_ON));

   assert_trip_ends_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ON && trip && enable) |=> (st_q == ST_DEAD && gate_vec == 4'b0000));

   assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (st_q == ST_IDLE));

endmodule

// File: tb/foc_chopper_test.sv
module foc_chopper_test;

   localparam int W = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n, enable, trip, trend_dec, polarity;
   logic [W-1:0] off_c, blank_c, fast_c, dead_c;
   logic         a_hi, a_lo, b_hi, b_lo;
   logic [3:0]   gates;
   assign gates = {a_hi, a_lo, b_hi, b_lo};

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   foc_chopper #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip),
      .trend_dec(trend_dec), .polarity(polarity),
      .off_cycles(off_c), .blank_cycles(blank_c),
      .fast_cycles(fast_c), .dead_cycles(dead_c),
      .gate_a_hi(a_hi), .gate_a_lo(a_lo), .gate_b_hi(b_hi), .gate_b_lo(b_lo)
   );

   // gate code {a_hi,a_lo,b_hi,b_lo} per R8
   function automatic logic [3:0] drive_code(input bit p);
      return p ? 4'b0110 : 4'b1001;
   endfunction

   function automatic logic [3:0] fast_code(input bit p);
      return p ? 4'b1001 : 4'b0110;
   endfunction

   // expected gates in off cycle j (1-based) per R6 / R7
   function automatic logic [3:0] off_code(input int j, input bit mixed,
                                           input int d, input int f, input bit p);
      if (j <= d) return 4'b0000;
      if (!mixed) return 4'b0101;
      if (j <= d + f) return fast_code(p);
      if (j <= 2*d + f) return 4'b0000;
      return 4'b0101;
   endfunction

   task automatic chk(input logic [3:0] exp, input string req);
      n_chk++;
      if (gates !== exp) begin
         n_bad++;
         $display("FAIL %s: gates got %b expected %b at %0t", req, gates, exp, $time);
      end
      n_chk++;
      if ((gates[3] && gates[2]) || (gates[1] && gates[0])) begin
         n_bad++;
         $display("FAIL R9 leg overlap: gates got %b expected no leg with both on", gates);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run got hung expected completion");
      summary();
      $finish;
   end

   initial begin
      int unsigned seed_v;
      int d, b, f, off, w;
      bit p0, p1, mx, drop, dropped;
      seed_v = $urandom(32'd4242);
      rst_n = 1'b0; enable = 1'b0; trip = 1'b0; trend_dec = 1'b0; polarity = 1'b0;
      off_c = 16'd10; blank_c = 16'd2; fast_c = 16'd2; dead_c = 16'd1;
      repeat (2) @(negedge clk);
      chk(4'b0000, "R1 in reset");
      enable = 1'b1; trip = 1'b1;
      @(negedge clk);
      chk(4'b0000, "R1 reset overrides enable");
      enable = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(4'b0000, "R1 disabled after reset");
      @(negedge clk);
      chk(4'b0000, "R1 trip with enable low");
      trip = 1'b0;
      @(negedge clk);

      for (int tr = 0; tr < 48; tr++) begin
         d = 1 + int'($urandom % 5);
         b = 1 + int'($urandom % 6);
         f = 1 + int'($urandom % 8);
         off = 2*d + f + 1 + int'($urandom % 16);
         w = int'($urandom % 5);
         p0 = 1'($urandom % 2);
         p1 = 1'($urandom % 2);
         mx = 1'($urandom % 2);
         drop = (($urandom % 4) == 0);
         if (tr == 0) begin d = 1; b = 1; f = 1; off = 4; mx = 1'b1; drop = 1'b0; w = 0; end
         if (tr == 1) begin d = 3; off = 4; mx = 1'b0; drop = 1'b0; end
         if (tr == 2) begin d = 2; b = 3; f = 5; off = 2*d + f + 1; mx = 1'b1; p0 = 1'b1; p1 = 1'b0; drop = 1'b0; end
         dead_c = W'(d); blank_c = W'(b); fast_c = W'(f); off_c = W'(off);
         polarity = p0;
         enable = 1'b1;
         for (int n = 1; n <= d; n++) begin
            @(negedge clk);
            chk(4'b0000, "R2 dead before drive");
         end
         for (int n = 1; n <= b; n++) begin
            @(negedge clk);
            chk(drive_code(p0), "R3 drive during blank");
            trip = 1'b1;
         end
         @(negedge clk);
         trip = 1'b0;
         chk(drive_code(p0), "R3 trip ignored in blank");
         for (int k = 0; k < w; k++) begin
            @(negedge clk);
            chk(drive_code(p0), "R4 drive held without trip");
         end
         trip = 1'b1;
         trend_dec = mx;
         dropped = 1'b0;
         for (int j = 1; j <= off; j++) begin
            @(negedge clk);
            trip = 1'b0;
            trend_dec = 1'($urandom % 2);
            chk(off_code(j, mx, d, f, p0), "R4/R5/R6/R7/R8 off-time pattern");
            if (j == 2) polarity = p1;
            if (drop && j == (off + 1) / 2) begin
               enable = 1'b0;
               #1;
               chk(4'b0000, "R10 gates drop with enable");
               dropped = 1'b1;
               break;
            end
         end
         if (dropped) begin
            @(negedge clk);
            chk(4'b0000, "R10 idle after mid-off disable");
            continue;
         end
         for (int n = 1; n <= d; n++) begin
            @(negedge clk);
            chk(4'b0000, "R2 dead after off-time");
         end
         for (int n = 1; n <= b; n++) begin
            @(negedge clk);
            chk(drive_code(p1), "R8 new polarity at turn-on");
         end
         enable = 1'b0;
         #1;
         chk(4'b0000, "R10 gates drop with enable");
         @(negedge clk);
         chk(4'b0000, "R10 stays idle");
      end

      summary();
      $finish;
   end

endmodule